// File: doc/BRIEF.md
# Break Trigger Pulse Output Controller

This debug-support block turns break-condition match strobes from two comparator channels into a pulse on an active-low trigger pin. Each channel has its own output-disable control. A 2-bit width code sets the pulse length to 1, 2, 4 or 8 bus clocks. The block also keeps one sticky match flag per channel, and software clears a flag by writing zero to it.

All state sits in a single 32-bit control word, reached through a plain write port and a readback port. The address and data comparators that raise the match strobes are outside the block, and so is any break exception toward a processor.

Top module: `brk_trig_ctl`

## Requirements
- R1: Bits 31:20 and 13:0 of the control word always read 0, and writing ones to them changes nothing.
- R2: After reset every defined control bit reads 0 and `trig_n_o` is high.
- R3: Bit 18 disables the trigger for channel 0. When it is 1, a channel 0 match produces no pulse. When it is 0, the match produces a pulse.
- R4: Bit 19 does the same for channel 1.
- R5: Bits 17:16 hold a width code W. A trigger pulse drives `trig_n_o` low for exactly 2^W clocks (1, 2, 4 or 8), starting the cycle after the clock edge that samples the enabled match.
- R6: Bit 15 is the channel 0 match flag. A match on channel 0 sets it, whether or not channel 0 is disabled.
- R7: Bit 14 is the channel 1 match flag, with the same behaviour.
- R8: A match flag clears only when a write carries 0 in its bit position. A write carrying 1 leaves the flag unchanged.
- R9: When a match and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: An enabled match that arrives during a pulse restarts the width count, so the low time runs a full width from the latest match.
- R11: A width code written during a pulse takes effect only on the next pulse.
- R12: An enabled match uses the disable bits held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word |
| match_i | input | 2 | Per-channel match strobes, bit 0 for channel 0 |
| trig_n_o | output | 1 | Active-low trigger pulse |

## Verification
Two things can land on the same cycle. A comparator strobe can set a flag while a software write clears it, and a strobe can arrive while a pulse is still running. The bench drives a match and a zero-carrying write on the same clock and expects the flag to read back set. It fires a second match partway through a pulse and expects the low time to equal the gap plus one full width. A third case rewrites the width code mid-pulse and expects the running pulse to keep its old length.

// File: rtl/brk_trig_pkg.sv
package brk_trig_pkg;
   localparam int REG_W     = 32;
   localparam int DIS0_BIT  = 18;
   localparam int WID_LSB   = 16;
   localparam int FLG0_BIT  = 15;
   localparam int RSVD_HI   = 20;

   function automatic int width_of(input int code);
      return 1 << code;
   endfunction
endpackage

// File: rtl/brk_trig_cfg.sv
module brk_trig_cfg
   import brk_trig_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int WID_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [NUM_CH-1:0] dis_q,
   output logic [WID_W-1:0]  wcode_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q   <= '0;
         wcode_q <= '0;
      end else if (wr_en) begin
         dis_q   <= wdata[DIS0_BIT +: NUM_CH];
         wcode_q <= wdata[WID_LSB +: WID_W];
      end
   end
endmodule

// File: rtl/brk_trig_flags.sv
module brk_trig_flags
   import brk_trig_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   input  logic [NUM_CH-1:0] match,
   output logic [NUM_CH-1:0] flag_q
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
      localparam int BITPOS = FLG0_BIT - c;
      logic clr;
      assign clr = wr_en && !wdata[BITPOS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[c] <= 1'b0;
         else if (match[c]) flag_q[c] <= 1'b1;   // set beats clear
         else if (clr)      flag_q[c] <= 1'b0;
      end
   end
endmodule

// File: rtl/brk_trig_pulse.sv
module brk_trig_pulse
   import brk_trig_pkg::*;
#(
   parameter int WID_W   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [WID_W-1:0] wcode,
   output logic             trig_n
);
   localparam int MAX_W = 1 << ((1 << WID_W) - 1);
   localparam int CNT_W = $clog2(MAX_W + 1);

   logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

   assign load_val = CNT_W'(1) << wcode;

   always_comb begin
      if (fire)             cnt_d = load_val;
      else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      else                  cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   if (OUT_REG) begin : g_oreg
      logic trig_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trig_q <= 1'b1;
         else        trig_q <= (cnt_d == '0);
      end
      assign trig_n = trig_q;
   end else begin : g_ocomb
      assign trig_n = (cnt_q == '0);
   end
endmodule

// File: rtl/brk_trig_ctl.sv
module brk_trig_ctl
   import brk_trig_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int WID_W   = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NUM_CH-1:0] match_i,
   output logic              trig_n_o
);
   if (NUM_CH < 1 || NUM_CH > 2) begin : g_bad_ch
      $error("NUM_CH must be 1 or 2");
   end
   if (WID_W < 1 || WID_W > 2) begin : g_bad_w
      $error("WID_W must be 1 or 2");
   end

   logic [NUM_CH-1:0] dis_q, flag_q;
   logic [WID_W-1:0]  wcode_q;
   logic              fire;

   brk_trig_cfg #(.NUM_CH(NUM_CH), .WID_W(WID_W)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .dis_q(dis_q), .wcode_q(wcode_q));

   brk_trig_flags #(.NUM_CH(NUM_CH)) flags_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .match(match_i), .flag_q(flag_q));

   assign fire = |(match_i & ~dis_q);

   brk_trig_pulse #(.WID_W(WID_W), .OUT_REG(OUT_REG)) pulse_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .wcode(wcode_q),
      .trig_n(trig_n_o));

   always_comb begin
      reg_rdata = '0;
      reg_rdata[WID_LSB +: WID_W] = wcode_q;
      for (int c = 0; c < NUM_CH; c++) begin
         reg_rdata[DIS0_BIT + c] = dis_q[c];
         reg_rdata[FLG0_BIT - c] = flag_q[c];
      end
   end
endmodule

// File: rtl/brk_trig_chk.sv
module brk_trig_chk
   import brk_trig_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic [1:0]       match_i,
   input logic             trig_n_o
);
   logic       fire_obs;
   logic [3:0] quiet_cnt;

   assign fire_obs = (match_i[0] && !reg_rdata[DIS0_BIT]) ||
                     (match_i[1] && !reg_rdata[DIS0_BIT+1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              quiet_cnt <= 4'd15;
      else if (fire_obs)       quiet_cnt <= 4'd0;
      else if (quiet_cnt != 15) quiet_cnt <= quiet_cnt + 4'd1;
   end

   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31:RSVD_HI] == '0 && reg_rdata[13:0] == '0);

   a_r5_fire_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      fire_obs |=> !trig_n_o);

   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_cnt >= 4'd8 |-> trig_n_o);

   a_r3_fall_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trig_n_o) |-> $past(fire_obs));

   a_r6_flag0_set: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[0] |=> reg_rdata[FLG0_BIT]);

   a_r7_flag1_set: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[1] |=> reg_rdata[FLG0_BIT-1]);

   a_r8_flag0_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[FLG0_BIT] && !(reg_wr_en && !reg_wdata[FLG0_BIT]))
      |=> reg_rdata[FLG0_BIT]);
endmodule

bind brk_trig_ctl brk_trig_chk chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .match_i(match_i), .trig_n_o(trig_n_o));

// File: tb/brk_trig_ctl_tb_top.sv
module brk_trig_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  match_i = '0;
   logic        trig_n_o;
   int          n_chk = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   brk_trig_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .match_i(match_i), .trig_n_o(trig_n_o));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d, input logic [1:0] m = 2'b00);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wdata = d; match_i = m;
      @(negedge clk);
      reg_wr_en = 1'b0; match_i = '0;
   endtask

   task automatic count_low(output int lows);
      lows = 0;
      for (int i = 0; i < 14; i++) begin
         if (!trig_n_o) lows++;
         @(negedge clk);
      end
   endtask

   task automatic fire(input logic [1:0] m);
      @(negedge clk); match_i = m;
      @(negedge clk); match_i = '0;
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end

   initial begin
      int lows;
      logic [31:0] cfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset word", reg_rdata, 0);
      check("R2 reset trig", trig_n_o, 1);

      wr(32'hFFFF_3FFF);
      check("R1 reserved ignored", reg_rdata, 32'h000F_0000);
      wr(32'h0);
      check("R1 cleared", reg_rdata, 0);

      // Sweep width code x disable pair x channel
      for (int code = 0; code < 4; code++)
         for (int dis = 0; dis < 4; dis++)
            for (int ch = 0; ch < 2; ch++) begin
               cfg = (32'(dis) << 18) | (32'(code) << 16);
               wr(cfg);
               fire(2'b01 << ch);
               count_low(lows);
               check(ch == 0 ? "R3/R5 ch0 pulse" : "R4/R5 ch1 pulse", lows,
                     dis[ch] ? 0 : (1 << code));
               check(ch == 0 ? "R6 flag0" : "R7 flag1",
                     reg_rdata[15 - ch], 1);
               wr(cfg | (32'h1 << (15 - ch)));
               check("R8 write one keeps", reg_rdata[15 - ch], 1);
               wr(cfg);
               check("R8 write zero clears", reg_rdata[15 - ch], 0);
            end

      // Set versus clear in the same cycle
      wr(32'h0, 2'b11);
      check("R9 set wins ch0", reg_rdata[15], 1);
      check("R9 set wins ch1", reg_rdata[14], 1);
      wr(32'h0);

      // Retrigger: width 4, second match two cycles after the first
      wr(32'h0002_0000);
      @(negedge clk); match_i = 2'b01;
      @(negedge clk); match_i = 2'b00;
      @(negedge clk); match_i = 2'b10;
      @(negedge clk); match_i = 2'b00;
      count_low(lows);
      check("R10 retrigger", lows + 2, 6);

      // Width change mid-pulse
      wr(32'h0003_0000);
      fire(2'b01);
      lows = 0;
      for (int i = 0; i < 2; i++) begin
         if (!trig_n_o) lows++;
         @(negedge clk);
      end
      reg_wr_en = 1'b1; reg_wdata = 32'h0;
      if (!trig_n_o) lows++;
      @(negedge clk);
      reg_wr_en = 1'b0;
      for (int i = 0; i < 12; i++) begin
         if (!trig_n_o) lows++;
         @(negedge clk);
      end
      check("R11 running pulse keeps width", lows, 8);
      fire(2'b01);
      count_low(lows);
      check("R11 next pulse new width", lows, 1);

      // Write of disable in same cycle as match uses old setting
      wr(32'h0004_0000, 2'b01);
      count_low(lows);
      check("R12 old disable used", lows, 1);
      fire(2'b01);
      count_low(lows);
      check("R12 new disable applies", lows, 0);

      finish_run();
   end
endmodule